// File: doc/BRIEF.md
# One-Time-Programmable Code Store Programming Controller

This block sits between the device's test-mode pins and a behavioural model of the on-chip one-time-programmable code store. It decodes which access the control-pin levels request: a signature read, a code verify, or one of four programming targets. These targets are the code array, a 32-byte scrambling key table and two lock bits. A programming request commits only after a counted burst of low pulses on the pulse line. Programming can only clear bits.

Readback of code goes through the key table. The byte driven out is the stored byte XNOR the key byte picked by the low five address bits. The key table itself is never readable. Lock bits refuse further code and key programming. The second lock bit also blanks code readback. All pins are sampled on the system clock, and the high-voltage supply is reduced to a single logic flag.

Top module: `otp_prog_ctrl`

## Requirements
- R1: A read access needs hold=1, strobe_n=0, pulse_n=1, ext_sel=1 and hv_on=0. Target select 4'b0000 is then a signature read and 4'b0011 is a code verify. Only in those two cases is d_out_en 1. Otherwise d_out_en is 0 and d_out is 8'h00.
- R2: A signature read returns 8'h15 at address 14'h030, 8'h99 at 14'h031 and 8'h00 at every other address.
- R3: After reset, every code byte and every key byte is erased (8'hFF), and both lock bits are clear. A code verify therefore returns 8'hFF.
- R4: Programming needs hold=1, strobe_n=0 and hv_on=1. Target select 4'b1011 picks the code array. A byte is committed on the clock that sees the PULSES-th (default 25) low-to-high transition of pulse_n. The committed value is the old byte AND d_in, and fewer pulses change nothing.
- R5: The pulse count restarts from zero whenever the address or the decoded access changes before the burst completes.
- R6: Target select 4'b1010 programs key byte a_in[4:0] (old AND d_in). A code verify returns code byte XNOR key byte a_in[4:0].
- R7: Target select 4'b1111 sets lock bit 1 and 4'b1100 sets lock bit 2, each after a full burst. While either lock bit is set, code and key bursts have no effect. The other lock bit can still be set, and lock bits only clear on reset.
- R8: With lock bit 2 set, a code verify returns 8'hFF with d_out_en still 1. Signature reads are unaffected.
- R9: Addresses at or above CODE_DEPTH verify as an erased byte (8'hFF before scrambling), and programming them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, erases the model |
| mode_hold | input | 1 | Level of the device reset pin (1 in all test accesses) |
| mode_strobe_n | input | 1 | Level of the program-fetch strobe pin |
| pgm_pulse_n | input | 1 | Programming pulse line, active low |
| ext_sel | input | 1 | Logic level of the external-access pin |
| hv_on | input | 1 | Programming supply present on the external-access pin |
| tgt_sel | input | 4 | Target select port bits, MSB first |
| a_in | input | 14 | Byte address |
| d_in | input | 8 | Programming data |
| d_out | output | 8 | Readback data |
| d_out_en | output | 1 | Readback drive enable (tri-state control) |

## Verification
Code, key and lock state can only be seen through readback. A wrong count, a misdecoded target or a stray commit stays hidden until a verify read reaches the affected byte. The bench's reference model is compared on every clock, so a wrong byte shows in the first cycle a verify addresses it. A commit that lands one pulse early or late shows as a changed or unchanged byte on the verify just after the 24th or 25th pulse. Key or lock corruption shows as scrambled or blanked data on addresses that were never programmed.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [2:0] {
        OM_IDLE,
        OM_SIG,
        OM_VERIFY,
        OM_PGM_CODE,
        OM_PGM_KEY,
        OM_PGM_LK1,
        OM_PGM_LK2
    } otp_mode_e;

    localparam logic [3:0] SEL_SIG    = 4'b0000;
    localparam logic [3:0] SEL_VERIFY = 4'b0011;
    localparam logic [3:0] SEL_CODE   = 4'b1011;
    localparam logic [3:0] SEL_KEY    = 4'b1010;
    localparam logic [3:0] SEL_LK1    = 4'b1111;
    localparam logic [3:0] SEL_LK2    = 4'b1100;

    function automatic logic is_pgm(otp_mode_e m);
        return (m == OM_PGM_CODE) || (m == OM_PGM_KEY) ||
               (m == OM_PGM_LK1)  || (m == OM_PGM_LK2);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_prog_pkg::*;
(
    input  logic       hold,
    input  logic       strobe_n,
    input  logic       pulse_n,
    input  logic       ext_sel,
    input  logic       hv_on,
    input  logic [3:0] sel,
    output otp_mode_e  mode_o
);
    always_comb begin
        mode_o = OM_IDLE;
        if (hold && !strobe_n) begin
            if (hv_on) begin
                case (sel)
                    SEL_CODE: mode_o = OM_PGM_CODE;
                    SEL_KEY:  mode_o = OM_PGM_KEY;
                    SEL_LK1:  mode_o = OM_PGM_LK1;
                    SEL_LK2:  mode_o = OM_PGM_LK2;
                    default:  mode_o = OM_IDLE;
                endcase
            end else if (ext_sel && pulse_n) begin
                case (sel)
                    SEL_SIG:    mode_o = OM_SIG;
                    SEL_VERIFY: mode_o = OM_VERIFY;
                    default:    mode_o = OM_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/otp_pulse_counter.sv
module otp_pulse_counter
    import otp_prog_pkg::*;
#(
    parameter int AW     = 14,
    parameter int PULSES = 25,
    localparam int CNT_W = $clog2(PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  otp_mode_e        mode,
    input  logic [AW-1:0]    addr,
    input  logic             pulse_n,
    output logic             commit_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        otp_mode_e        mode;
        logic [AW-1:0]    addr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic rise;

    always_comb begin
        ctr_d       = ctr_q;
        commit_o    = 1'b0;
        rise        = pulse_n && !ctr_q.pulse;
        ctr_d.pulse = pulse_n;
        ctr_d.mode  = mode;
        ctr_d.addr  = addr;
        if (mode != ctr_q.mode || addr != ctr_q.addr) begin
            ctr_d.cnt = '0;
        end else if (is_pgm(mode) && rise) begin
            if (ctr_q.cnt == CNT_W'(PULSES - 1)) begin
                commit_o  = 1'b1;
                ctr_d.cnt = '0;
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt   <= '0;
            ctr_q.pulse <= 1'b1;
            ctr_q.mode  <= OM_IDLE;
            ctr_q.addr  <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o = ctr_q.cnt;
endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_prog_pkg::*;
#(
    parameter int AW         = 14,
    parameter int CODE_DEPTH = 256,
    parameter int KEY_DEPTH  = 32,
    localparam int CODE_AW   = $clog2(CODE_DEPTH),
    localparam int KEY_AW    = $clog2(KEY_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  otp_mode_e     mode,
    input  logic          commit,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en,
    output logic [1:0]    lock_o
);
    typedef struct packed {
        logic [CODE_DEPTH-1:0][7:0] code;
        logic [KEY_DEPTH-1:0][7:0]  key;
        logic [1:0]                 lock;
    } store_t;

    store_t st_d, st_q;
    logic               in_range;
    logic               locked;
    logic [CODE_AW-1:0] cidx;
    logic [KEY_AW-1:0]  kidx;
    logic [7:0]         raw;

    assign in_range = (addr >> CODE_AW) == '0;
    assign cidx     = addr[CODE_AW-1:0];
    assign kidx     = addr[KEY_AW-1:0];
    assign locked   = |st_q.lock;
    assign raw      = in_range ? st_q.code[cidx] : 8'hFF;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            case (mode)
                OM_PGM_CODE: if (!locked && in_range) st_d.code[cidx] = st_q.code[cidx] & din;
                OM_PGM_KEY:  if (!locked) st_d.key[kidx] = st_q.key[kidx] & din;
                OM_PGM_LK1:  st_d.lock[0] = 1'b1;
                OM_PGM_LK2:  st_d.lock[1] = 1'b1;
                default:     st_d = st_q;
            endcase
        end
    end

    always_comb begin
        dout    = 8'h00;
        dout_en = 1'b0;
        case (mode)
            OM_SIG: begin
                dout_en = 1'b1;
                if (addr == AW'(14'h030))      dout = 8'h15;
                else if (addr == AW'(14'h031)) dout = 8'h99;
            end
            OM_VERIFY: begin
                dout_en = 1'b1;
                dout    = st_q.lock[1] ? 8'hFF : (raw ~^ st_q.key[kidx]);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= '1;
            st_q.key  <= '1;
            st_q.lock <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_prog_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int CODE_DEPTH = 256,
    parameter int PULSES     = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_hold,
    input  logic              mode_strobe_n,
    input  logic              pgm_pulse_n,
    input  logic              ext_sel,
    input  logic              hv_on,
    input  logic [3:0]        tgt_sel,
    input  logic [ADDR_W-1:0] a_in,
    input  logic [7:0]        d_in,
    output logic [7:0]        d_out,
    output logic              d_out_en
);
    localparam int CNT_W = $clog2(PULSES + 1);

    otp_mode_e        mode;
    logic             commit;
    logic [CNT_W-1:0] pulse_cnt;
    logic [1:0]       lock_st;

    otp_mode_decode u_dec (
        .hold    (mode_hold),
        .strobe_n(mode_strobe_n),
        .pulse_n (pgm_pulse_n),
        .ext_sel (ext_sel),
        .hv_on   (hv_on),
        .sel     (tgt_sel),
        .mode_o  (mode)
    );

    otp_pulse_counter #(.AW(ADDR_W), .PULSES(PULSES)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .addr    (a_in),
        .pulse_n (pgm_pulse_n),
        .commit_o(commit),
        .cnt_o   (pulse_cnt)
    );

    otp_store #(.AW(ADDR_W), .CODE_DEPTH(CODE_DEPTH), .KEY_DEPTH(32)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .commit (commit),
        .addr   (a_in),
        .din    (d_in),
        .dout   (d_out),
        .dout_en(d_out_en),
        .lock_o (lock_st)
    );
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk #(
    parameter int ADDR_W = 14,
    parameter int PULSES = 25,
    localparam int CNT_W = $clog2(PULSES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_hold,
    input logic              mode_strobe_n,
    input logic              pgm_pulse_n,
    input logic              ext_sel,
    input logic              hv_on,
    input logic [3:0]        tgt_sel,
    input logic [ADDR_W-1:0] a_in,
    input logic [7:0]        d_out,
    input logic              d_out_en,
    input logic [CNT_W-1:0]  pulse_cnt,
    input logic [1:0]        lock_st
);
    a_r1_en_needs_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        d_out_en |-> (mode_hold && !mode_strobe_n && pgm_pulse_n && ext_sel && !hv_on));

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !d_out_en |-> (d_out == 8'h00));

    a_r2_sig_first: assert property (@(posedge clk) disable iff (!rst_n)
        (d_out_en && tgt_sel == 4'b0000 && a_in == ADDR_W'(14'h030)) |-> (d_out == 8'h15));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt < CNT_W'(PULSES));

    a_r5_addr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_in) |=> (pulse_cnt == '0));

    a_r7_lock1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_st[0] |=> lock_st[0]);

    a_r7_lock2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_st[1] |=> lock_st[1]);

    a_r8_lock2_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (d_out_en && tgt_sel == 4'b0011 && lock_st[1]) |-> (d_out == 8'hFF));
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(.ADDR_W(ADDR_W), .PULSES(PULSES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_hold    (mode_hold),
    .mode_strobe_n(mode_strobe_n),
    .pgm_pulse_n  (pgm_pulse_n),
    .ext_sel      (ext_sel),
    .hv_on        (hv_on),
    .tgt_sel      (tgt_sel),
    .a_in         (a_in),
    .d_out        (d_out),
    .d_out_en     (d_out_en),
    .pulse_cnt    (pulse_cnt),
    .lock_st      (lock_st)
);

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hold = 1'b0;
    logic        mode_strobe_n = 1'b1;
    logic        pgm_pulse_n = 1'b1;
    logic        ext_sel = 1'b0;
    logic        hv_on = 1'b0;
    logic [3:0]  tgt_sel = 4'b0000;
    logic [13:0] a_in = '0;
    logic [7:0]  d_in = '0;
    logic [7:0]  d_out;
    logic        d_out_en;

    int    tests = 0;
    int    fails = 0;
    string phase = "R1";

    // reference state
    logic [7:0] m_code [256];
    logic [7:0] m_key  [32];
    logic       m_lk1, m_lk2;
    int         m_cnt;
    int         m_prev_mode;
    logic [13:0] m_prev_addr;
    logic       m_prev_pulse;

    always #10 clk = ~clk;

    otp_prog_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_hold(mode_hold), .mode_strobe_n(mode_strobe_n),
        .pgm_pulse_n(pgm_pulse_n), .ext_sel(ext_sel), .hv_on(hv_on), .tgt_sel(tgt_sel),
        .a_in(a_in), .d_in(d_in), .d_out(d_out), .d_out_en(d_out_en)
    );

    // 0 idle, 1 signature, 2 verify, 3 code, 4 key, 5 lock1, 6 lock2
    function automatic int ref_mode();
        if (!(mode_hold && !mode_strobe_n)) return 0;
        if (hv_on) begin
            if (tgt_sel == 4'b1011) return 3;
            if (tgt_sel == 4'b1010) return 4;
            if (tgt_sel == 4'b1111) return 5;
            if (tgt_sel == 4'b1100) return 6;
            return 0;
        end
        if (!(ext_sel && pgm_pulse_n)) return 0;
        if (tgt_sel == 4'b0000) return 1;
        if (tgt_sel == 4'b0011) return 2;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int md;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_code[i] = 8'hFF;
            for (int i = 0; i < 32; i++) m_key[i] = 8'hFF;
            m_lk1 = 0; m_lk2 = 0; m_cnt = 0;
            m_prev_mode = 0; m_prev_addr = '0; m_prev_pulse = 1;
        end else begin
            md = ref_mode();
            if (md != m_prev_mode || a_in != m_prev_addr) m_cnt = 0;
            else if (md >= 3 && pgm_pulse_n && !m_prev_pulse) begin
                m_cnt++;
                if (m_cnt == 25) begin
                    m_cnt = 0;
                    if (md == 3 && !(m_lk1 || m_lk2) && a_in < 256) m_code[a_in] = m_code[a_in] & d_in;
                    if (md == 4 && !(m_lk1 || m_lk2)) m_key[a_in % 32] = m_key[a_in % 32] & d_in;
                    if (md == 5) m_lk1 = 1;
                    if (md == 6) m_lk2 = 1;
                end
            end
            m_prev_mode = md; m_prev_addr = a_in; m_prev_pulse = pgm_pulse_n;
        end
    end

    function automatic logic [8:0] ref_out();
        int md = ref_mode();
        logic [7:0] raw;
        if (md == 1) begin
            if (a_in == 14'h030) return {1'b1, 8'h15};
            if (a_in == 14'h031) return {1'b1, 8'h99};
            return {1'b1, 8'h00};
        end
        if (md == 2) begin
            if (m_lk2) return {1'b1, 8'hFF};
            raw = (a_in < 256) ? m_code[a_in] : 8'hFF;
            return {1'b1, raw ~^ m_key[a_in % 32]};
        end
        return 9'h000;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [8:0] e;
            e = ref_out();
            tests++;
            if ({d_out_en, d_out} !== e) begin
                fails++;
                $display("FAIL %s cycle compare: actual en=%0b d=%02h expected en=%0b d=%02h",
                         phase, d_out_en, d_out, e[8], e[7:0]);
            end
        end
    end

    task automatic chk(string req, logic exp_en, logic [7:0] exp_d);
        @(negedge clk);
        tests++;
        if (d_out_en !== exp_en || d_out !== exp_d) begin
            fails++;
            $display("FAIL %s: actual en=%0b d=%02h expected en=%0b d=%02h",
                     req, d_out_en, d_out, exp_en, exp_d);
        end
    endtask

    task automatic go_read(logic [3:0] s, logic [13:0] a);
        @(posedge clk); #2;
        mode_hold = 1; mode_strobe_n = 0; pgm_pulse_n = 1; ext_sel = 1; hv_on = 0;
        tgt_sel = s; a_in = a;
    endtask

    task automatic go_pgm(logic [3:0] s, logic [13:0] a, logic [7:0] d);
        @(posedge clk); #2;
        mode_hold = 1; mode_strobe_n = 0; pgm_pulse_n = 1; ext_sel = 1; hv_on = 1;
        tgt_sel = s; a_in = a; d_in = d;
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2; pgm_pulse_n = 0;
            @(posedge clk); #2; pgm_pulse_n = 1;
        end
        @(posedge clk); #2;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        phase = "R1";
        chk("R1 idle after reset", 1'b0, 8'h00);
        go_read(4'b0101, 14'h030);
        chk("R1 unknown select", 1'b0, 8'h00);

        phase = "R2";
        go_read(4'b0000, 14'h030); chk("R2 sig 030", 1'b1, 8'h15);
        go_read(4'b0000, 14'h031); chk("R2 sig 031", 1'b1, 8'h99);
        go_read(4'b0000, 14'h032); chk("R2 sig other", 1'b1, 8'h00);

        phase = "R3";
        go_read(4'b0011, 14'h000); chk("R3 erased 000", 1'b1, 8'hFF);
        go_read(4'b0011, 14'h005); chk("R3 erased 005", 1'b1, 8'hFF);

        phase = "R4";
        go_pgm(4'b1011, 14'h005, 8'hA5); pulses(24);
        go_read(4'b0011, 14'h005); chk("R4 24 pulses no commit", 1'b1, 8'hFF);
        go_pgm(4'b1011, 14'h005, 8'hA5); pulses(25);
        go_read(4'b0011, 14'h005); chk("R4 25 pulses commit", 1'b1, 8'hA5);
        go_pgm(4'b1011, 14'h005, 8'h0F); pulses(25);
        go_read(4'b0011, 14'h005); chk("R4 clear-only AND", 1'b1, 8'h05);

        phase = "R5";
        go_pgm(4'b1011, 14'h006, 8'h00); pulses(20);
        go_pgm(4'b1011, 14'h007, 8'h00);
        go_pgm(4'b1011, 14'h006, 8'h00); pulses(10);
        go_read(4'b0011, 14'h006); chk("R5 restart on address change", 1'b1, 8'hFF);
        go_read(4'b0011, 14'h007); chk("R5 other address untouched", 1'b1, 8'hFF);
        go_pgm(4'b1011, 14'h006, 8'h00); pulses(25);
        go_read(4'b0011, 14'h006); chk("R5 full burst after restart", 1'b1, 8'h00);

        phase = "R6";
        go_pgm(4'b1010, 14'h005, 8'hF0); pulses(25);
        go_read(4'b0011, 14'h005); chk("R6 scrambled verify", 1'b1, 8'h0A);
        go_read(4'b0011, 14'h025); chk("R6 key picked by low 5 bits", 1'b1, 8'hF0);
        go_read(4'b0011, 14'h004); chk("R6 other key byte erased", 1'b1, 8'hFF);

        phase = "R9";
        go_pgm(4'b1011, 14'h100, 8'h00); pulses(25);
        go_read(4'b0011, 14'h100); chk("R9 out of range reads erased", 1'b1, 8'hFF);

        phase = "R7";
        go_pgm(4'b1111, 14'h000, 8'h00); pulses(25);
        go_pgm(4'b1011, 14'h009, 8'h00); pulses(25);
        go_read(4'b0011, 14'h009); chk("R7 code refused after lock1", 1'b1, 8'hFF);
        go_pgm(4'b1010, 14'h009, 8'h00); pulses(25);
        go_read(4'b0011, 14'h009); chk("R7 key refused after lock1", 1'b1, 8'hFF);
        go_read(4'b0011, 14'h005); chk("R7 readback still open", 1'b1, 8'h0A);

        phase = "R8";
        go_pgm(4'b1100, 14'h000, 8'h00); pulses(25);
        go_read(4'b0011, 14'h006); chk("R8 lock2 blanks verify", 1'b1, 8'hFF);
        go_read(4'b0000, 14'h031); chk("R8 signature after lock2", 1'b1, 8'h99);

        phase = "R3";
        @(posedge clk); #2 rst_n = 0;
        @(posedge clk); #2 rst_n = 1;
        go_read(4'b0011, 14'h006); chk("R3 reset erases store", 1'b1, 8'hFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule